// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Sign-Class Status Flags

This execute-stage unit receives a 16-bit instruction word together with the two source register values that a register file has read for it. It performs one of three operations: wrapping two's-complement addition, bitwise AND, or bitwise inversion of the first source. The second operand is either the second register value or a 5-bit immediate taken from the instruction and sign-extended. Register and immediate modes are chosen by a single instruction bit.

The unit decodes the register indices from the instruction. The source indices go out combinationally, so the register file can present the operand values in the same cycle. The result, its destination index and a one-cycle valid strobe come out one clock after the instruction is accepted. Every result also loads a three-bit status register that classifies it as negative, zero or positive. Exactly one bit of that register is set. The register is kept stable between results so that a branch unit can compare it against an instruction mask. Unsupported opcodes pass through without any effect.

Top module: `nzp_alu_unit`

## Requirements
- R1: The opcode is instruction bits [15:12]. The value 4'b0001 selects addition, 4'b0101 selects AND and 4'b1001 selects inversion. Each of these raises `result_valid` for exactly one cycle, in the cycle after it is accepted.
- R2: The destination index is instruction bits [11:9] and appears on `dst_idx` alongside the result. The source indices `src_a_idx` (bits [8:6]) and `src_b_idx` (bits [2:0]) follow the instruction combinationally.
- R3: When instruction bit 5 is 1, operand two is bits [4:0] sign-extended to 16 bits. This covers the range -16 to +15, and `src_b_val` is ignored.
- R4: When instruction bit 5 is 0, operand two is `src_b_val`, and instruction bits [4:3] have no effect.
- R5: Addition wraps modulo 2^16 and raises no overflow indication.
- R6: AND produces the bitwise AND of operand one and operand two.
- R7: Inversion produces the bitwise complement of `src_a_val`. Bit 5 and bits [4:0] are ignored.
- R8: Every result loads `nzp` as follows: bit 2 (N) for a negative result, bit 1 (Z) for all zeros, bit 0 (P) for positive. Exactly one bit is set.
- R9: Any other opcode raises no strobe and leaves `nzp` unchanged.
- R10: A synchronous reset sets `nzp` to 3'b010 and clears `result_valid`, `result` and `dst_idx`.
- R11: When `instr_valid` is low, no strobe is raised and `nzp` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| src_a_val | input | 16 | Value of the first source register |
| src_b_val | input | 16 | Value of the second source register |
| src_a_idx | output | 3 | Index of the first source register |
| src_b_idx | output | 3 | Index of the second source register |
| dst_idx | output | 3 | Destination index for the result |
| result | output | 16 | Operation result |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| nzp | output | 3 | Negative/zero/positive status flags |

## Verification
The assertions assume that `instr_valid`, `instr` and the source values are settled, known values before each rising edge. They also assume that reset is held for at least one edge before any instruction is presented. The stimulus meets both conditions. It changes every input only on the falling clock edge and holds reset over several edges at start-up. It asserts reset again only between instructions. It never depends on undefined register values, because the source values are always driven, including for opcodes that ignore them.

// File: rtl/alu_nzp_pkg.sv
package alu_nzp_pkg;

    localparam int INSTR_W   = 16;
    localparam int OPC_W     = 4;
    localparam int REG_IDX_W = 3;
    localparam int IMM_W     = 5;

    localparam int OPC_LSB   = 12;
    localparam int DST_LSB   = 9;
    localparam int SRCA_LSB  = 6;
    localparam int SRCB_LSB  = 0;
    localparam int MODE_BIT  = 5;
    localparam int IMM_LSB   = 0;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_INV  = 2'd3
    } alu_op_e;

    typedef logic [2:0] nzp_t;
    localparam nzp_t NZP_NEG  = 3'b100;
    localparam nzp_t NZP_ZERO = 3'b010;
    localparam nzp_t NZP_POS  = 3'b001;

    typedef struct packed {
        alu_op_e                 op;
        logic                    use_imm;
        logic [REG_IDX_W-1:0]    dst;
        logic [REG_IDX_W-1:0]    src_a;
        logic [REG_IDX_W-1:0]    src_b;
        logic [IMM_W-1:0]        imm;
    } dec_t;

    function automatic alu_op_e opc_to_op(input logic [OPC_W-1:0] opc);
        alu_op_e r;
        case (opc)
            OPC_ADD: r = ALU_ADD;
            OPC_AND: r = ALU_AND;
            OPC_NOT: r = ALU_INV;
            default: r = ALU_NONE;
        endcase
        return r;
    endfunction

    function automatic nzp_t classify(input logic sign, input logic all_zero);
        nzp_t r;
        if (all_zero)  r = NZP_ZERO;
        else if (sign) r = NZP_NEG;
        else           r = NZP_POS;
        return r;
    endfunction

endpackage

// File: rtl/instr_decoder.sv
module instr_decoder
    import alu_nzp_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    always_comb begin
        dec.op      = opc_to_op(instr[OPC_LSB +: OPC_W]);
        dec.use_imm = instr[MODE_BIT];
        dec.dst     = instr[DST_LSB  +: REG_IDX_W];
        dec.src_a   = instr[SRCA_LSB +: REG_IDX_W];
        dec.src_b   = instr[SRCB_LSB +: REG_IDX_W];
        dec.imm     = instr[IMM_LSB  +: IMM_W];
    end
endmodule

// File: rtl/operand_mux.sv
module operand_mux #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] opnd
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_extend
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    assign opnd = use_imm ? imm_ext : reg_val;

    // R3
    imm_sign_chk: assert final (!use_imm || opnd[DATA_W-1] == imm[IMM_W-1]);
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_nzp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              wr,
    output nzp_t              flags
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_INV: y = ~a;
            default: y = '0;
        endcase
    end

    assign wr    = (op != ALU_NONE);
    assign flags = classify(y[DATA_W-1], (y == '0));
endmodule

// File: rtl/nzp_reg.sv
module nzp_reg
    import alu_nzp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  nzp_t flags_in,
    output nzp_t nzp
);
    always_ff @(posedge clk) begin
        if (rst)      nzp <= NZP_ZERO;
        else if (wr)  nzp <= flags_in;
    end

    // R8
    nzp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(nzp) == 1);

    // R9
    nzp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(nzp));
endmodule

// File: rtl/nzp_alu_unit.sv
module nzp_alu_unit
    import alu_nzp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    src_a_val,
    input  logic [DATA_W-1:0]    src_b_val,
    output logic [REG_IDX_W-1:0] src_a_idx,
    output logic [REG_IDX_W-1:0] src_b_idx,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [DATA_W-1:0]    result,
    output logic                 result_valid,
    output logic [2:0]           nzp
);
    dec_t              dec;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_y;
    logic              alu_wr;
    nzp_t              alu_flags;
    logic              commit;
    nzp_t              nzp_q;

    instr_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    operand_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_mux (
        .use_imm (dec.use_imm),
        .imm     (dec.imm),
        .reg_val (src_b_val),
        .opnd    (opnd_b)
    );

    alu_core #(.DATA_W(DATA_W)) u_alu (
        .op    (dec.op),
        .a     (src_a_val),
        .b     (opnd_b),
        .y     (alu_y),
        .wr    (alu_wr),
        .flags (alu_flags)
    );

    assign commit = instr_valid && alu_wr;

    nzp_reg u_nzp (
        .clk      (clk),
        .rst      (rst),
        .wr       (commit),
        .flags_in (alu_flags),
        .nzp      (nzp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            dst_idx      <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= commit;
            if (commit) begin
                result  <= alu_y;
                dst_idx <= dec.dst;
            end
        end
    end

    assign src_a_idx = dec.src_a;
    assign src_b_idx = dec.src_b;
    assign nzp       = nzp_q;

    // R11
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(instr_valid));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (nzp[1] == (result == '0)));

    // R8
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (nzp[2] == result[DATA_W-1]));

    // R9
    idle_nzp_chk: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> (nzp == $past(nzp)) || $past(rst));
endmodule

// File: tb/nzp_alu_unit_test.sv
`timescale 1ns/1ps
module nzp_alu_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr;
    logic [15:0] src_a_val, src_b_val;
    logic [2:0]  src_a_idx, src_b_idx, dst_idx;
    logic [15:0] result;
    logic        result_valid;
    logic [2:0]  nzp;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    nzp_alu_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .src_a_val(src_a_val), .src_b_val(src_b_val),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .result(result), .result_valid(result_valid), .nzp(nzp)
    );

    typedef struct packed {
        logic [15:0] ins;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] res;
        logic [2:0]  dst;
        logic [2:0]  flags;
        logic        ok;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{16'h1283, 16'h0005, 16'h0007, 16'h000C, 3'd1, 3'b001, 1'b1},
        '{16'h173F, 16'h0001, 16'h5555, 16'h0000, 3'd3, 3'b010, 1'b1},
        '{16'h1430, 16'h0003, 16'h0000, 16'hFFF3, 3'd2, 3'b100, 1'b1},
        '{16'h106F, 16'h0000, 16'h0000, 16'h000F, 3'd0, 3'b001, 1'b1},
        '{16'h1E01, 16'hFFFF, 16'h0001, 16'h0000, 3'd7, 3'b010, 1'b1},
        '{16'h1E01, 16'h7FFF, 16'h0001, 16'h8000, 3'd7, 3'b100, 1'b1},
        '{16'h0E05, 16'h1111, 16'h2222, 16'h0000, 3'd0, 3'b100, 1'b0},
        '{16'h5946, 16'hF0F0, 16'h3C3C, 16'h3030, 3'd4, 3'b001, 1'b1},
        '{16'hF025, 16'h0000, 16'h0000, 16'h0000, 3'd0, 3'b001, 1'b0},
        '{16'h5BBF, 16'h8001, 16'h0000, 16'h8001, 3'd5, 3'b100, 1'b1},
        '{16'h5C20, 16'hFFFF, 16'hFFFF, 16'h0000, 3'd6, 3'b010, 1'b1},
        '{16'h3283, 16'h8000, 16'h0001, 16'h0000, 3'd0, 3'b010, 1'b0},
        '{16'h92BF, 16'h00FF, 16'h1234, 16'hFF00, 3'd1, 3'b100, 1'b1},
        '{16'h94C5, 16'hFFFF, 16'h0000, 16'h0000, 3'd2, 3'b010, 1'b1},
        '{16'h94C5, 16'h8000, 16'h0000, 16'h7FFF, 3'd2, 3'b001, 1'b1},
        '{16'h1283, 16'h8000, 16'h8000, 16'h0000, 3'd1, 3'b010, 1'b1},
        '{16'h129B, 16'h0001, 16'h0002, 16'h0003, 3'd1, 3'b001, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string op_req(input logic [3:0] opc);
        case (opc)
            4'b0001: return "R5 add result";
            4'b0101: return "R6 and result";
            default: return "R7 not result";
        endcase
    endfunction

    task automatic issue(input logic v, input logic [15:0] i,
                         input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        instr_valid = v;
        instr       = i;
        src_a_val   = a;
        src_b_val   = b;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    initial begin
        #(4 * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr = 16'h0000;
        src_a_val = 16'h0000; src_b_val = 16'h0000;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 nzp after reset", {13'd0, nzp}, 16'h0002);
        chk("R10 strobe after reset", {15'd0, result_valid}, 16'h0000);
        chk("R10 result after reset", result, 16'h0000);
        chk("R10 dst after reset", {13'd0, dst_idx}, 16'h0000);
        rst = 1'b0;

        // R2 combinational source indices
        instr = 16'h0B83;
        #1;
        chk("R2 src_a_idx", {13'd0, src_a_idx}, 16'h0006);
        chk("R2 src_b_idx", {13'd0, src_b_idx}, 16'h0003);

        // table walk: R1 R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            issue(1'b1, VEC[k].ins, VEC[k].a, VEC[k].b);
            chk("R1 strobe", {15'd0, result_valid}, {15'd0, VEC[k].ok});
            chk(VEC[k].ok ? "R8 flags" : "R9 flags held",
                {13'd0, nzp}, {13'd0, VEC[k].flags});
            if (VEC[k].ok) begin
                chk(op_req(VEC[k].ins[15:12]), result, VEC[k].res);
                chk("R2 dst_idx", {13'd0, dst_idx}, {13'd0, VEC[k].dst});
            end
            @(negedge clk);
            chk("R1 strobe one cycle", {15'd0, result_valid}, 16'h0000);
        end

        // R3 immediate ignores src_b_val: ADD R4,R0,#-16 with src_b all ones
        issue(1'b1, 16'h1830, 16'h0010, 16'hFFFF);
        chk("R3 imm add result", result, 16'h0000);
        chk("R3 imm add flags", {13'd0, nzp}, 16'h0002);

        // R4 register mode, same word with bit5 clear uses src_b_val
        issue(1'b1, 16'h1810, 16'h0010, 16'hFFFF);
        chk("R4 reg add result", result, 16'h000F);
        chk("R4 reg add flags", {13'd0, nzp}, 16'h0001);

        // R11 instr_valid low: AND giving negative must not land
        issue(1'b0, 16'h5946, 16'h8000, 16'h8000);
        chk("R11 no strobe", {15'd0, result_valid}, 16'h0000);
        chk("R11 nzp held", {13'd0, nzp}, 16'h0001);
        chk("R11 result held", result, 16'h000F);

        // back-to-back strobes
        @(negedge clk);
        instr_valid = 1'b1; instr = 16'h1283; src_a_val = 16'hFFFE; src_b_val = 16'h0001;
        @(negedge clk);
        chk("R1 back-to-back first", result, 16'hFFFF);
        chk("R8 back-to-back first flags", {13'd0, nzp}, 16'h0004);
        instr = 16'h5946; src_a_val = 16'h00FF; src_b_val = 16'h0F0F;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R1 back-to-back strobe", {15'd0, result_valid}, 16'h0001);
        chk("R6 back-to-back second", result, 16'h000F);
        chk("R2 back-to-back dst", {13'd0, dst_idx}, 16'h0004);

        // R10 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 nzp after late reset", {13'd0, nzp}, 16'h0002);
        chk("R10 result after late reset", result, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule